// File: doc/BRIEF.md
# Paged Program Sequencer with Two-Deep Return Stack

This block produces the fetch address for a 512-word program store split into eight 64-word pages. It holds a 9-bit program counter and a two-entry return stack. Each clock is one instruction cycle. An external decoder presents a decoded operation code together with an address operand. The block then selects the next address. The choices are the following word, an absolute target, a target inside the current page or page pair, an entry into the fixed subroutine page, a call, a return, or an indirect target read from the program store.

Two operations use two cycles. The indirect jump puts an address built from the accumulator and memory nibbles on the fetch bus and then loads the low byte of the counter from the returned byte. The indirect load saves the return address on the stack and fetches the table byte, strobing it into an external 8-bit latch. It then restores the counter from the stack. A return-with-skip flags the next fetched word as discarded. A separate skip input from the skip logic discards the current word.

Top module: `pc_sequencer`

## Requirements
- R1: While reset is asserted, and for two clock edges after it is released, pc_o is 0 and q_load_o and discard_o are 0. Reset also clears both stack entries, so a return (code 5) issued first yields address 0.
- R2: For op code 0, and for every unassigned code 9 to 15, the counter takes pc+1 modulo 512. It crosses page boundaries freely and wraps from 511 to 0.
- R3: A call (code 4) loads operand_i into the counter. The top stack entry receives pc+1, and the old top moves to the second entry.
- R4: A return (code 5) loads the counter from the top entry and moves the second entry to the top, leaving the second entry unchanged. Return-with-skip (code 6) does the same and also drives discard_o high in the next cycle.
- R5: A subroutine-page entry (code 3) sets bits 8:6 to 010 and bits 5:0 to operand_i[5:0], and pushes pc+1 like a call.
- R6: An in-page jump (code 2) takes its page from pc+1. If pc+1 lies in page 2 or 3 (bits 8:7 = 01), it replaces bits 6:0 with operand_i[6:0]; otherwise it replaces bits 5:0 with operand_i[5:0].
- R7: A long jump (code 1) loads all nine bits of operand_i.
- R8: An indirect jump (code 7) first presents {bit 8 of pc+1, acc_i, mem_i} on pc_o. On the next edge it loads bits 7:0 from rom_data_i and keeps bit 8.
- R9: An indirect load (code 8) pushes pc+1 and presents {bit 8 of pc+1, acc_i, mem_i}. In that second cycle q_load_o is high for one cycle only. The counter then takes the top entry, and the second entry is copied into the top, so the entry it held before the push is lost.
- R10: In a cycle where discard_o or skip_i is high (outside the second cycle of an indirect operation), op_i and operand_i are ignored and the counter advances by one.
- R11: In the second cycle of an indirect operation, op_i and skip_i are ignored and discard_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction-cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Decoded operation code |
| skip_i | input | 1 | Discard the current word |
| operand_i | input | 9 | Target address operand |
| acc_i | input | 4 | Accumulator nibble for indirect addressing |
| mem_i | input | 4 | Memory nibble for indirect addressing |
| rom_data_i | input | 8 | Byte read at pc_o |
| pc_o | output | 9 | Program fetch address |
| q_load_o | output | 1 | Strobe that loads rom_data_i into the output latch |
| discard_o | output | 1 | Current word is skipped after a return-with-skip |

## Verification
The properties check the local timing rules on every cycle: plain increment with wraparound, advance during a discarded word, the discard flag after a return-with-skip, the fixed subroutine page, bit 8 kept through an indirect jump, and a single-cycle load strobe that follows each indirect load. The data flow through the stack can only be shown by the bench's scenarios, which follow a call chain. Those scenarios cover the entry lost after a third push or after an indirect load, page-pair and last-word jumps, and the byte returned by the program store during the indirect cycles.

// File: rtl/pcseq_pkg.sv
`timescale 1ns/1ps
package pcseq_pkg;
  localparam int OP_W = 4;

  localparam logic [OP_W-1:0] OPC_SEQ   = 4'd0;
  localparam logic [OP_W-1:0] OPC_JMP   = 4'd1;
  localparam logic [OP_W-1:0] OPC_JP    = 4'd2;
  localparam logic [OP_W-1:0] OPC_JSRP  = 4'd3;
  localparam logic [OP_W-1:0] OPC_JSR   = 4'd4;
  localparam logic [OP_W-1:0] OPC_RET   = 4'd5;
  localparam logic [OP_W-1:0] OPC_RETSK = 4'd6;
  localparam logic [OP_W-1:0] OPC_JID   = 4'd7;
  localparam logic [OP_W-1:0] OPC_LQID  = 4'd8;

  typedef enum logic [1:0] {
    PH_RUN   = 2'd0,
    PH_IJMP  = 2'd1,
    PH_ILOAD = 2'd2
  } phase_e;

  typedef enum logic [2:0] {
    SEL_INC,
    SEL_ABS,
    SEL_PAGE,
    SEL_SUBPG,
    SEL_TOP,
    SEL_IND,
    SEL_ROM
  } pc_sel_e;
endpackage

// File: rtl/pcseq_rst_sync.sv
`timescale 1ns/1ps
module pcseq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sr_q <= '0;
    else          sr_q <= {sr_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sr_q[STAGES-1];
endmodule

// File: rtl/pcseq_ctrl.sv
`timescale 1ns/1ps
module pcseq_ctrl import pcseq_pkg::*; (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] op_i,
  input  logic            skip_i,
  output pc_sel_e         sel_o,
  output logic            push_o,
  output logic            pop_o,
  output logic            q_load_o,
  output logic            discard_o,
  output phase_e          phase_o
);
  phase_e phase_q, phase_d;
  logic   disc_q, disc_d;
  logic   ignore;

  assign ignore = skip_i | disc_q;

  always_comb begin
    sel_o    = SEL_INC;
    push_o   = 1'b0;
    pop_o    = 1'b0;
    q_load_o = 1'b0;
    phase_d  = PH_RUN;
    disc_d   = 1'b0;
    case (phase_q)
      PH_IJMP: begin
        sel_o = SEL_ROM;
      end
      PH_ILOAD: begin
        sel_o    = SEL_TOP;
        pop_o    = 1'b1;
        q_load_o = 1'b1;
      end
      default: begin
        if (!ignore) begin
          case (op_i)
            OPC_JMP:  sel_o = SEL_ABS;
            OPC_JP:   sel_o = SEL_PAGE;
            OPC_JSRP: begin
              sel_o  = SEL_SUBPG;
              push_o = 1'b1;
            end
            OPC_JSR: begin
              sel_o  = SEL_ABS;
              push_o = 1'b1;
            end
            OPC_RET: begin
              sel_o = SEL_TOP;
              pop_o = 1'b1;
            end
            OPC_RETSK: begin
              sel_o  = SEL_TOP;
              pop_o  = 1'b1;
              disc_d = 1'b1;
            end
            OPC_JID: begin
              sel_o   = SEL_IND;
              phase_d = PH_IJMP;
            end
            OPC_LQID: begin
              sel_o   = SEL_IND;
              push_o  = 1'b1;
              phase_d = PH_ILOAD;
            end
            default: sel_o = SEL_INC;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_RUN;
      disc_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      disc_q  <= disc_d;
    end
  end

  assign discard_o = disc_q;
  assign phase_o   = phase_q;
endmodule

// File: rtl/pcseq_stack.sv
`timescale 1ns/1ps
module pcseq_stack #(
  parameter int AW    = 9,
  parameter int DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [AW-1:0] push_val_i,
  output logic [AW-1:0] top_o
);
  logic [DEPTH-1:0][AW-1:0] stk_q, stk_d;
  logic                     stk_en;

  assign stk_en = push_i | pop_i;

  always_comb begin
    stk_d = stk_q;
    if (push_i) begin
      stk_d[0] = push_val_i;
      for (int i = 1; i < DEPTH; i++) stk_d[i] = stk_q[i-1];
    end else if (pop_i) begin
      for (int i = 0; i < DEPTH-1; i++) stk_d[i] = stk_q[i+1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      stk_q <= '0;
    else if (stk_en) stk_q <= stk_d;
  end

  assign top_o = stk_q[0];
endmodule

// File: rtl/pcseq_target.sv
`timescale 1ns/1ps
module pcseq_target import pcseq_pkg::*; #(
  parameter int AW       = 9,
  parameter int PAGE_W   = 6,
  parameter int NIB_W    = 4,
  parameter int BYTE_W   = 8,
  parameter int SUB_PAGE = 2
) (
  input  logic [AW-1:0]     pc_q_i,
  input  logic [AW-1:0]     operand_i,
  input  logic [NIB_W-1:0]  acc_i,
  input  logic [NIB_W-1:0]  mem_i,
  input  logic [BYTE_W-1:0] rom_data_i,
  input  logic [AW-1:0]     stack_top_i,
  input  pc_sel_e           sel_i,
  output logic [AW-1:0]     pc_inc_o,
  output logic [AW-1:0]     pc_d_o
);
  localparam int PG_NUM_W = AW - PAGE_W;
  localparam int PAIR_W   = PG_NUM_W - 1;
  localparam logic [PG_NUM_W-1:0] SUB_ID  = PG_NUM_W'(SUB_PAGE);
  localparam logic [PAIR_W-1:0]   PAIR_ID = PAIR_W'(SUB_PAGE / 2);

  logic [AW-1:0] pc_inc, page_tgt;
  logic          in_pair;

  assign pc_inc  = pc_q_i + AW'(1);
  assign in_pair = (pc_inc[AW-1:PAGE_W+1] == PAIR_ID);

  always_comb begin
    if (in_pair) page_tgt = {pc_inc[AW-1:PAGE_W+1], operand_i[PAGE_W:0]};
    else         page_tgt = {pc_inc[AW-1:PAGE_W],   operand_i[PAGE_W-1:0]};
  end

  always_comb begin
    case (sel_i)
      SEL_ABS:   pc_d_o = operand_i;
      SEL_PAGE:  pc_d_o = page_tgt;
      SEL_SUBPG: pc_d_o = {SUB_ID, operand_i[PAGE_W-1:0]};
      SEL_TOP:   pc_d_o = stack_top_i;
      SEL_IND:   pc_d_o = {pc_inc[AW-1:2*NIB_W], acc_i, mem_i};
      SEL_ROM:   pc_d_o = {pc_q_i[AW-1:BYTE_W], rom_data_i};
      default:   pc_d_o = pc_inc;
    endcase
  end

  assign pc_inc_o = pc_inc;
endmodule

// File: rtl/pc_sequencer.sv
`timescale 1ns/1ps
module pc_sequencer import pcseq_pkg::*; #(
  parameter int AW          = 9,
  parameter int PAGE_W      = 6,
  parameter int NIB_W       = 4,
  parameter int BYTE_W      = 8,
  parameter int SUB_PAGE    = 2,
  parameter int DEPTH       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   op_i,
  input  logic              skip_i,
  input  logic [AW-1:0]     operand_i,
  input  logic [NIB_W-1:0]  acc_i,
  input  logic [NIB_W-1:0]  mem_i,
  input  logic [BYTE_W-1:0] rom_data_i,
  output logic [AW-1:0]     pc_o,
  output logic              q_load_o,
  output logic              discard_o
);
  logic          rst_int_n;
  logic [AW-1:0] pc_q, pc_d, pc_inc, stack_top;
  logic          push, pop;
  pc_sel_e       sel;
  phase_e        phase_q;

  pcseq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_int_n)
  );

  pcseq_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .op_i      (op_i),
    .skip_i    (skip_i),
    .sel_o     (sel),
    .push_o    (push),
    .pop_o     (pop),
    .q_load_o  (q_load_o),
    .discard_o (discard_o),
    .phase_o   (phase_q)
  );

  pcseq_target #(
    .AW(AW), .PAGE_W(PAGE_W), .NIB_W(NIB_W), .BYTE_W(BYTE_W), .SUB_PAGE(SUB_PAGE)
  ) u_tgt (
    .pc_q_i      (pc_q),
    .operand_i   (operand_i),
    .acc_i       (acc_i),
    .mem_i       (mem_i),
    .rom_data_i  (rom_data_i),
    .stack_top_i (stack_top),
    .sel_i       (sel),
    .pc_inc_o    (pc_inc),
    .pc_d_o      (pc_d)
  );

  pcseq_stack #(.AW(AW), .DEPTH(DEPTH)) u_stk (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .push_i     (push),
    .pop_i      (pop),
    .push_val_i (pc_inc),
    .top_o      (stack_top)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) pc_q <= '0;
    else            pc_q <= pc_d;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/pcseq_checker.sv
`timescale 1ns/1ps
module pcseq_checker import pcseq_pkg::*; #(
  parameter int AW       = 9,
  parameter int PAGE_W   = 6,
  parameter int SUB_PAGE = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic [OP_W-1:0] op_i,
  input logic            skip_i,
  input logic            discard_o,
  input logic            q_load_o,
  input phase_e          phase_i,
  input logic [AW-1:0]   pc_i
);
  logic live;
  assign live = (phase_i == PH_RUN) && !skip_i && !discard_o;

  p_seq_incr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (live && op_i == OPC_SEQ) |=> (pc_i == AW'($past(pc_i) + AW'(1))));

  p_discard_adv_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_i == PH_RUN && discard_o) |=> (!discard_o && pc_i == AW'($past(pc_i) + AW'(1))));

  p_retsk_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (live && op_i == OPC_RETSK) |=> discard_o);

  p_subpage_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (live && op_i == OPC_JSRP) |=> (pc_i[AW-1:PAGE_W] == (AW-PAGE_W)'(SUB_PAGE)));

  p_ind_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_i == PH_IJMP) |=> (pc_i[AW-1] == $past(pc_i[AW-1])));

  p_lqid_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (live && op_i == OPC_LQID) |=> q_load_o);

  p_load_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    q_load_o |=> !q_load_o);

  p_second_nodisc_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_i != PH_RUN) |-> !discard_o);
endmodule

bind pc_sequencer pcseq_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .op_i      (op_i),
  .skip_i    (skip_i),
  .discard_o (discard_o),
  .q_load_o  (q_load_o),
  .phase_i   (phase_q),
  .pc_i      (pc_o)
);

// File: tb/pc_sequencer_test.sv
`timescale 1ns/1ps
module pc_sequencer_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] op_i;
  logic       skip_i;
  logic [8:0] operand_i;
  logic [3:0] acc_i, mem_i;
  logic [7:0] rom_data_i;
  logic [8:0] pc_o;
  logic       q_load_o, discard_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [8:0] m_pc, m_sa, m_sb;
  logic [1:0] m_ph;
  logic       m_disc;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] rom_fn(input logic [8:0] a);
    return (a[7:0] * 8'd29) ^ {7'd0, a[8]} ^ 8'hC3;
  endfunction

  assign rom_data_i = rom_fn(pc_o);

  pc_sequencer uut (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .skip_i(skip_i), .operand_i(operand_i),
    .acc_i(acc_i), .mem_i(mem_i), .rom_data_i(rom_data_i),
    .pc_o(pc_o), .q_load_o(q_load_o), .discard_o(discard_o)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_outputs(input string t);
    chk(t, "pc", 32'(pc_o), 32'(m_pc));
    chk(t, "load", 32'(q_load_o), 32'(m_ph == 2'd2));
    chk(t, "discard", 32'(discard_o), 32'(m_disc));
  endtask

  // Drive one instruction cycle; the expected next state follows the requirements.
  task automatic apply(input string tag, input logic [3:0] op, input logic [8:0] opd,
                       input logic [3:0] a, input logic [3:0] m, input logic sk);
    string t;
    logic [8:0] inc, n_pc, n_sa, n_sb;
    logic [1:0] n_ph;
    logic n_d, ign;
    op_i = op; operand_i = opd; acc_i = a; mem_i = m; skip_i = sk;
    inc = m_pc + 9'd1;
    n_pc = inc; n_sa = m_sa; n_sb = m_sb; n_ph = 2'd0; n_d = 1'b0;
    ign = (m_ph == 2'd0) && (sk || m_disc);
    t = "R2";
    if (m_ph == 2'd1) begin
      n_pc = {m_pc[8], rom_fn(m_pc)};
      t = (op != 4'd0 || sk) ? "R11" : "R8";
    end else if (m_ph == 2'd2) begin
      n_pc = m_sa; n_sa = m_sb;
      t = (op != 4'd0 || sk) ? "R11" : "R9";
    end else if (ign) begin
      t = "R10";
    end else begin
      case (op)
        4'd1: begin n_pc = opd; t = "R7"; end
        4'd2: begin
          if (inc[8:7] == 2'b01) n_pc = {inc[8:7], opd[6:0]};
          else                   n_pc = {inc[8:6], opd[5:0]};
          t = "R6";
        end
        4'd3: begin n_pc = {3'b010, opd[5:0]}; n_sa = inc; n_sb = m_sa; t = "R5"; end
        4'd4: begin n_pc = opd; n_sa = inc; n_sb = m_sa; t = "R3"; end
        4'd5: begin n_pc = m_sa; n_sa = m_sb; t = "R4"; end
        4'd6: begin n_pc = m_sa; n_sa = m_sb; n_d = 1'b1; t = "R4"; end
        4'd7: begin n_pc = {inc[8], a, m}; n_ph = 2'd1; t = "R8"; end
        4'd8: begin n_pc = {inc[8], a, m}; n_sa = inc; n_sb = m_sa; n_ph = 2'd2; t = "R9"; end
        default: t = "R2";
      endcase
    end
    if (tag != "") t = tag;
    @(posedge clk);
    m_pc = n_pc; m_sa = n_sa; m_sb = n_sb; m_ph = n_ph; m_disc = n_d;
    @(negedge clk);
    chk_outputs(t);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R2 actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; op_i = '0; skip_i = 1'b0; operand_i = '0; acc_i = '0; mem_i = '0;
    m_pc = '0; m_sa = '0; m_sb = '0; m_ph = '0; m_disc = 1'b0;
    repeat (3) @(negedge clk);
    chk_outputs("R1");
    rst_n = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk_outputs("R1");

    // R1: cleared stack returns to 0
    apply("R1", 4'd5, 9'h000, 4'h0, 4'h0, 1'b0);
    // R2: increment, page crossing, wrap, unassigned code
    repeat (3) apply("", 4'd0, 9'h1AB, 4'h0, 4'h0, 1'b0);
    apply("", 4'd1, 9'h03F, 4'h0, 4'h0, 1'b0);
    apply("R2", 4'd0, 9'h000, 4'h0, 4'h0, 1'b0);
    apply("", 4'd1, 9'h1FF, 4'h0, 4'h0, 1'b0);
    apply("R2", 4'd0, 9'h000, 4'h0, 4'h0, 1'b0);
    apply("R2", 4'd12, 9'h0F0, 4'h0, 4'h0, 1'b0);
    // R6: last word of page 1 lands in page pair; last word of page 0; inside page 2
    apply("", 4'd1, 9'h07F, 4'h0, 4'h0, 1'b0);
    apply("R6", 4'd2, 9'h045, 4'h0, 4'h0, 1'b0);
    apply("", 4'd1, 9'h03F, 4'h0, 4'h0, 1'b0);
    apply("R6", 4'd2, 9'h1D5, 4'h0, 4'h0, 1'b0);
    apply("", 4'd1, 9'h0A0, 4'h0, 4'h0, 1'b0);
    apply("R6", 4'd2, 9'h010, 4'h0, 4'h0, 1'b0);
    // R3, R5, R4: nested calls, third push drops oldest entry
    apply("", 4'd1, 9'h100, 4'h0, 4'h0, 1'b0);
    apply("R3", 4'd4, 9'h150, 4'h0, 4'h0, 1'b0);
    apply("R3", 4'd4, 9'h020, 4'h0, 4'h0, 1'b0);
    apply("R5", 4'd3, 9'h12A, 4'h0, 4'h0, 1'b0);
    apply("R4", 4'd5, 9'h000, 4'h0, 4'h0, 1'b0);
    apply("R4", 4'd6, 9'h000, 4'h0, 4'h0, 1'b0);
    // R10: discarded word, then skip input
    apply("R10", 4'd1, 9'h000, 4'h0, 4'h0, 1'b0);
    apply("R10", 4'd1, 9'h077, 4'h0, 4'h0, 1'b1);
    // R8 / R11: indirect jump, second cycle ignores op and skip
    apply("R8", 4'd7, 9'h000, 4'h5, 4'hA, 1'b0);
    apply("R11", 4'd1, 9'h033, 4'h0, 4'h0, 1'b1);
    // R9: indirect load loses the older entry
    apply("", 4'd1, 9'h1C0, 4'h0, 4'h0, 1'b0);
    apply("R3", 4'd4, 9'h030, 4'h0, 4'h0, 1'b0);
    apply("R3", 4'd4, 9'h060, 4'h0, 4'h0, 1'b0);
    apply("R9", 4'd8, 9'h000, 4'h3, 4'h7, 1'b0);
    apply("R11", 4'd6, 9'h000, 4'h0, 4'h0, 1'b0);
    apply("R9", 4'd5, 9'h000, 4'h0, 4'h0, 1'b0);
    apply("R9", 4'd5, 9'h000, 4'h0, 4'h0, 1'b0);

    for (int i = 0; i < 4000; i++) begin
      apply("", 4'($urandom_range(0, 15)), 9'($urandom_range(0, 511)),
            4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)),
            ($urandom_range(0, 7) == 0));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule